// File: doc/BRIEF.md
# Register Write-Hazard Scoreboard

This block tracks which architectural registers have a write in flight. It holds one pending bit per register. A bit rises when a requester (a function unit slot) accepts an instruction that will write that register. The bit falls when the register file takes the result. It also falls when the requester finishes without a valid result, so a unit that drops its write cannot leave the register blocked for ever.

The issue logic sends a one-hot vector of the registers that the next instruction reads, and gets back a single hazard flag. The flag is high when any of those registers still has a write in flight, which is a read-after-write conflict, so the instruction must wait. Every requester presents its own set and clear requests. These are merged by OR into one set vector and one clear vector before they reach the storage.

A build-time parameter picks how register selects arrive on the destination and writeback ports: as a binary index or as a one-hot vector. The check vector is always one-hot.

Top module: `wr_hazard_scoreboard`

## Requirements
- R1: While reset is low, and on the first clock after it is released, every bit of `pend_o` is 0.
- R2: When a requester has `issue_i`, `sel_i` and `wr_flag_i` all high in a cycle, bit `dst_i` of `pend_o` is 1 after the next rising edge. If `sel_i` or `wr_flag_i` is low, `pend_o` is not set. Bits with no set or clear request keep their value.
- R3: When a requester has `wb_en_i` high, bit `wb_sel_i` of `pend_o` is 0 after the next rising edge, unless a set targets the same bit.
- R4: With `SEL_MODE` = binary (0), each select field is `clog2(NUM_REGS)` bits wide and holds the register index. With one-hot (1), the field is `NUM_REGS` bits wide and bit k selects register k. Both modes give identical `pend_o` and `hazard_o` for the same register choices.
- R5: When a requester raises `done_i` with `res_ok_i` low while its latched write flag is 1, the pending bit of its latched destination is cleared at the next edge. `done_i` with `res_ok_i` high clears nothing by itself.
- R6: Each requester latches `wr_flag_i` and `dst_i` in a cycle with `issue_i` and `sel_i` high. In any other cycle with `busy_i` low, the latched flag drops to 0, and a later `done_i` without a result then clears nothing.
- R7: If a set and a clear hit the same bit in the same cycle, the bit ends at 1.
- R8: `hazard_o` is 1 exactly when `pend_o & chk_i` is nonzero. It follows the present stored bits within the same cycle and ignores set and clear requests of that cycle.
- R9: Set and clear requests from different requesters in the same cycle all take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| issue_i | input | NUM_REQ | Per-requester issue strobe |
| sel_i | input | NUM_REQ | Requester is the one picked for this issue |
| wr_flag_i | input | NUM_REQ | Issued instruction writes a register |
| dst_i | input | NUM_REQ*SEL_W | Destination select per requester, at issue |
| busy_i | input | NUM_REQ | Requester holds an instruction |
| wb_en_i | input | NUM_REQ | Register file accepts this requester's write |
| wb_sel_i | input | NUM_REQ*SEL_W | Register select of the accepted write |
| done_i | input | NUM_REQ | Requester finishes its instruction |
| res_ok_i | input | NUM_REQ | Requester produced a valid result |
| chk_i | input | NUM_REGS | One-hot set of registers the issuing instruction reads |
| pend_o | output | NUM_REGS | Pending-write bit per register |
| hazard_o | output | 1 | Read-after-write conflict on a checked register |

## Verification
`hazard_o` is due in the same cycle as `chk_i` and reflects only the bits already stored. `pend_o` moves exactly one rising edge after a set, a writeback or a no-result completion. The bench drives inputs on the falling edge. It checks `hazard_o` one nanosecond later against the model's state before the edge, then waits through the rising edge and compares `pend_o` and `hazard_o` at the following falling edge, after the model has applied the same cycle's requests. A binary-select instance and a one-hot instance share all stimulus, so any difference between the two select modes appears as a mismatch on the one-hot copy.

// File: rtl/sb_pkg.sv
package sb_pkg;
  typedef enum logic {
    SEL_BINARY = 1'b0,
    SEL_ONEHOT = 1'b1
  } sel_mode_e;

  function automatic int sel_width(input int regs, input sel_mode_e mode);
    if (mode == SEL_ONEHOT) return regs;
    return (regs > 1) ? $clog2(regs) : 1;
  endfunction
endpackage

// File: rtl/sb_sel_decode.sv
module sb_sel_decode
  import sb_pkg::*;
#(
  parameter int        NUM_REGS = 32,
  parameter sel_mode_e SEL_MODE = SEL_BINARY,
  parameter int        SEL_W    = sel_width(NUM_REGS, SEL_MODE)
) (
  input  logic                en_i,
  input  logic [SEL_W-1:0]    sel_i,
  output logic [NUM_REGS-1:0] vec_o
);
  generate
    if (SEL_MODE == SEL_BINARY) begin : g_bin
      localparam logic [NUM_REGS-1:0] ONE = NUM_REGS'(1);
      assign vec_o = en_i ? (ONE << sel_i) : '0;
    end else begin : g_hot
      assign vec_o = en_i ? NUM_REGS'(sel_i) : '0;
    end
  endgenerate
endmodule

// File: rtl/sb_requester.sv
module sb_requester
  import sb_pkg::*;
#(
  parameter int        NUM_REGS = 32,
  parameter sel_mode_e SEL_MODE = SEL_BINARY,
  parameter int        SEL_W    = sel_width(NUM_REGS, SEL_MODE)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                issue_i,
  input  logic                sel_i,
  input  logic                wr_flag_i,
  input  logic [SEL_W-1:0]    dst_i,
  input  logic                busy_i,
  input  logic                wb_en_i,
  input  logic [SEL_W-1:0]    wb_sel_i,
  input  logic                done_i,
  input  logic                res_ok_i,
  output logic [NUM_REGS-1:0] set_vec_o,
  output logic [NUM_REGS-1:0] clr_vec_o
);
  logic             wr_pend_q;
  logic [SEL_W-1:0] dst_q;
  logic             take, set_en, nores;
  logic [NUM_REGS-1:0] wb_vec, nr_vec;

  assign take   = issue_i & sel_i;
  assign set_en = take & wr_flag_i;
  // unit ends without result although a write was expected
  assign nores  = done_i & wr_pend_q & ~res_ok_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_pend_q <= 1'b0;
      dst_q     <= '0;
    end else if (take) begin
      wr_pend_q <= wr_flag_i;
      dst_q     <= dst_i;
    end else if (!busy_i) begin
      wr_pend_q <= 1'b0;
    end
  end

  sb_sel_decode #(.NUM_REGS(NUM_REGS), .SEL_MODE(SEL_MODE), .SEL_W(SEL_W)) u_set_dec (
    .en_i(set_en), .sel_i(dst_i), .vec_o(set_vec_o)
  );

  sb_sel_decode #(.NUM_REGS(NUM_REGS), .SEL_MODE(SEL_MODE), .SEL_W(SEL_W)) u_wb_dec (
    .en_i(wb_en_i), .sel_i(wb_sel_i), .vec_o(wb_vec)
  );

  sb_sel_decode #(.NUM_REGS(NUM_REGS), .SEL_MODE(SEL_MODE), .SEL_W(SEL_W)) u_nr_dec (
    .en_i(nores), .sel_i(dst_q), .vec_o(nr_vec)
  );

  assign clr_vec_o = wb_vec | nr_vec;
endmodule

// File: rtl/sb_bitvec.sv
module sb_bitvec #(
  parameter int NUM_REGS = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_REGS-1:0] set_i,
  input  logic [NUM_REGS-1:0] clr_i,
  input  logic [NUM_REGS-1:0] chk_i,
  output logic [NUM_REGS-1:0] pend_o,
  output logic                hazard_o
);
  logic [NUM_REGS-1:0] pend_q;

  // set applied after clear: a new issue beats a stale writeback
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= (pend_q & ~clr_i) | set_i;
  end

  assign pend_o   = pend_q;
  assign hazard_o = |(pend_q & chk_i);
endmodule

// File: rtl/wr_hazard_scoreboard.sv
module wr_hazard_scoreboard
  import sb_pkg::*;
#(
  parameter int        NUM_REGS = 32,
  parameter int        NUM_REQ  = 4,
  parameter sel_mode_e SEL_MODE = SEL_BINARY,
  localparam int       SEL_W    = sel_width(NUM_REGS, SEL_MODE)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [NUM_REQ-1:0]         issue_i,
  input  logic [NUM_REQ-1:0]         sel_i,
  input  logic [NUM_REQ-1:0]         wr_flag_i,
  input  logic [NUM_REQ*SEL_W-1:0]   dst_i,
  input  logic [NUM_REQ-1:0]         busy_i,
  input  logic [NUM_REQ-1:0]         wb_en_i,
  input  logic [NUM_REQ*SEL_W-1:0]   wb_sel_i,
  input  logic [NUM_REQ-1:0]         done_i,
  input  logic [NUM_REQ-1:0]         res_ok_i,
  input  logic [NUM_REGS-1:0]        chk_i,
  output logic [NUM_REGS-1:0]        pend_o,
  output logic                       hazard_o
);
  logic [NUM_REQ-1:0][NUM_REGS-1:0] set_req, clr_req;
  logic [NUM_REGS-1:0]              set_all, clr_all;

  generate
    for (genvar g = 0; g < NUM_REQ; g++) begin : g_req
      sb_requester #(.NUM_REGS(NUM_REGS), .SEL_MODE(SEL_MODE), .SEL_W(SEL_W)) u_req (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .issue_i   (issue_i[g]),
        .sel_i     (sel_i[g]),
        .wr_flag_i (wr_flag_i[g]),
        .dst_i     (dst_i[g*SEL_W +: SEL_W]),
        .busy_i    (busy_i[g]),
        .wb_en_i   (wb_en_i[g]),
        .wb_sel_i  (wb_sel_i[g*SEL_W +: SEL_W]),
        .done_i    (done_i[g]),
        .res_ok_i  (res_ok_i[g]),
        .set_vec_o (set_req[g]),
        .clr_vec_o (clr_req[g])
      );
    end
  endgenerate

  always_comb begin
    set_all = '0;
    clr_all = '0;
    for (int r = 0; r < NUM_REQ; r++) begin
      set_all |= set_req[r];
      clr_all |= clr_req[r];
    end
  end

  sb_bitvec #(.NUM_REGS(NUM_REGS)) u_bits (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .set_i    (set_all),
    .clr_i    (clr_all),
    .chk_i    (chk_i),
    .pend_o   (pend_o),
    .hazard_o (hazard_o)
  );
endmodule

// File: rtl/sb_scoreboard_chk.sv
module sb_scoreboard_chk #(
  parameter int NUM_REGS = 32
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic [NUM_REGS-1:0] set_vec_i,
  input logic [NUM_REGS-1:0] clr_vec_i,
  input logic [NUM_REGS-1:0] chk_i,
  input logic [NUM_REGS-1:0] pend_i,
  input logic                hazard_i
);
  logic armed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed_q <= 1'b0;
    else         armed_q <= 1'b1;
  end

  AST_RESET_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !armed_q |-> (pend_i == '0)); // R1

  AST_SET_LANDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_vec_i != '0) |=> ((pend_i & $past(set_vec_i)) == $past(set_vec_i))); // R2

  AST_UNTOUCHED_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (((pend_i ^ $past(pend_i)) & ~$past(set_vec_i | clr_vec_i)) == '0)); // R2

  AST_CLEAR_LANDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((clr_vec_i & ~set_vec_i) != '0) |=> ((pend_i & $past(clr_vec_i & ~set_vec_i)) == '0)); // R3

  AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((set_vec_i & clr_vec_i) != '0) |=>
      ((pend_i & $past(set_vec_i & clr_vec_i)) == $past(set_vec_i & clr_vec_i))); // R7

  AST_NO_HAZARD_UNCHECKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chk_i == '0) |-> !hazard_i); // R8

  AST_NO_HAZARD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_i == '0) |-> !hazard_i); // R8
endmodule

bind wr_hazard_scoreboard sb_scoreboard_chk #(.NUM_REGS(NUM_REGS)) u_sb_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .set_vec_i(set_all),
  .clr_vec_i(clr_all),
  .chk_i    (chk_i),
  .pend_i   (pend_o),
  .hazard_i (hazard_o)
);

// File: tb/sim_wr_hazard_scoreboard.sv
`timescale 1ns/1ps
module sim_wr_hazard_scoreboard;
  import sb_pkg::*;

  localparam int NREG = 32;
  localparam int NREQ = 4;
  localparam int AW   = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [NREQ-1:0] b_issue = '0, b_sel = '0, b_wr = '0, b_busy = '0;
  logic [NREQ-1:0] b_wb = '0, b_done = '0, b_ok = '0;
  int              b_dst[NREQ];
  int              b_wbsel[NREQ];
  logic [NREG-1:0] b_chk = '0;

  logic [NREQ*AW-1:0]   dst_bin, wbs_bin;
  logic [NREQ*NREG-1:0] dst_hot, wbs_hot;
  logic [NREG-1:0]      p0, p1;
  logic                 h0, h1;

  always_comb begin
    for (int i = 0; i < NREQ; i++) begin
      dst_bin[i*AW +: AW]     = AW'(b_dst[i]);
      wbs_bin[i*AW +: AW]     = AW'(b_wbsel[i]);
      dst_hot[i*NREG +: NREG] = NREG'(1) << b_dst[i];
      wbs_hot[i*NREG +: NREG] = NREG'(1) << b_wbsel[i];
    end
  end

  wr_hazard_scoreboard #(.NUM_REGS(NREG), .NUM_REQ(NREQ), .SEL_MODE(SEL_BINARY)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .issue_i(b_issue), .sel_i(b_sel), .wr_flag_i(b_wr),
    .dst_i(dst_bin), .busy_i(b_busy), .wb_en_i(b_wb), .wb_sel_i(wbs_bin),
    .done_i(b_done), .res_ok_i(b_ok), .chk_i(b_chk), .pend_o(p0), .hazard_o(h0)
  );

  wr_hazard_scoreboard #(.NUM_REGS(NREG), .NUM_REQ(NREQ), .SEL_MODE(SEL_ONEHOT)) u1 (
    .clk_i(clk), .rst_ni(rst_n), .issue_i(b_issue), .sel_i(b_sel), .wr_flag_i(b_wr),
    .dst_i(dst_hot), .busy_i(b_busy), .wb_en_i(b_wb), .wb_sel_i(wbs_hot),
    .done_i(b_done), .res_ok_i(b_ok), .chk_i(b_chk), .pend_o(p1), .hazard_o(h1)
  );

  // behavioural reference
  logic [NREG-1:0] m_pend;
  logic [NREQ-1:0] m_lflag;
  int              m_ldst[NREQ];

  always @(posedge clk or negedge rst_n) begin : model
    logic [NREG-1:0] s, c;
    if (!rst_n) begin
      m_pend  = '0;
      m_lflag = '0;
      for (int i = 0; i < NREQ; i++) m_ldst[i] = 0;
    end else begin
      s = '0;
      c = '0;
      for (int i = 0; i < NREQ; i++) begin
        if (b_issue[i] && b_sel[i] && b_wr[i]) s[b_dst[i]] = 1'b1;
        if (b_wb[i]) c[b_wbsel[i]] = 1'b1;
        if (b_done[i] && m_lflag[i] && !b_ok[i]) c[m_ldst[i]] = 1'b1;
      end
      for (int i = 0; i < NREQ; i++) begin
        if (b_issue[i] && b_sel[i]) begin
          m_lflag[i] = b_wr[i];
          m_ldst[i]  = b_dst[i];
        end else if (!b_busy[i]) begin
          m_lflag[i] = 1'b0;
        end
      end
      m_pend = (m_pend & ~c) | s;
    end
  end

  int n_cmp = 0;
  int n_bad = 0;
  bit fin = 1'b0;

  task automatic chk(input string req, input string what,
                     input logic [NREG-1:0] act, input logic [NREG-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic bit_chk(input string req, input string what, input logic act, input logic exp);
    chk(req, what, NREG'(act), NREG'(exp));
  endtask

  // called at a falling edge with inputs just set
  task automatic tick(input string req);
    #1;
    bit_chk("R8", "hazard before edge u0", h0, |(m_pend & b_chk));
    bit_chk("R4", "hazard before edge u1", h1, |(m_pend & b_chk));
    @(posedge clk);
    @(negedge clk);
    chk(req,  "pend u0", p0, m_pend);
    chk("R4", "pend u1", p1, m_pend);
    bit_chk(req,  "hazard u0", h0, |(m_pend & b_chk));
    bit_chk("R4", "hazard u1", h1, |(m_pend & b_chk));
  endtask

  task automatic idle();
    b_issue = '0; b_sel = '0; b_wr = '0; b_busy = '0;
    b_wb = '0; b_done = '0; b_ok = '0;
    for (int i = 0; i < NREQ; i++) begin
      b_dst[i] = 0;
      b_wbsel[i] = 0;
    end
  endtask

  task automatic issue(input int r, input logic s, input logic w, input int d);
    b_issue[r] = 1'b1; b_sel[r] = s; b_wr[r] = w; b_dst[r] = d;
  endtask

  // random-phase driver state
  bit rs_act[NREQ];
  int rs_cnt[NREQ];
  bit rs_wr[NREQ];
  bit rs_res[NREQ];
  int rs_dst[NREQ];

  initial begin
    idle();
    for (int i = 0; i < NREQ; i++) rs_act[i] = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1", "pend in reset u0", p0, '0);
    chk("R1", "pend in reset u1", p1, '0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "pend after reset u0", p0, '0);
    chk("R1", "pend after reset u1", p1, '0);

    // set, with same-cycle hazard unaffected
    idle(); b_chk = NREG'(1) << 5; issue(0, 1, 1, 5);
    tick("R8");
    bit_chk("R2", "bit5 set", p0[5], 1'b1);
    bit_chk("R8", "hazard on bit5", h0, 1'b1);

    // not selected / no write flag
    idle(); b_busy[0] = 1'b1; issue(1, 0, 1, 6); issue(2, 1, 0, 7);
    tick("R2");
    bit_chk("R2", "bit6 unselected", p0[6], 1'b0);
    bit_chk("R2", "bit7 no wr flag", p0[7], 1'b0);

    // two requesters in one cycle
    idle(); b_busy[0] = 1'b1; issue(1, 1, 1, 20); issue(2, 1, 1, 21);
    tick("R9");
    bit_chk("R9", "bit20 set", p0[20], 1'b1);
    bit_chk("R9", "bit21 set", p0[21], 1'b1);

    // writeback clear
    idle(); b_busy = 4'b0111; b_wb[0] = 1'b1; b_wbsel[0] = 5; b_done[0] = 1'b1; b_ok[0] = 1'b1;
    tick("R3");
    bit_chk("R3", "bit5 cleared", p0[5], 1'b0);
    bit_chk("R8", "hazard gone", h0, 1'b0);

    // set and clear same bit
    idle(); b_busy = 4'b0110; issue(3, 1, 1, 20);
    b_wb[1] = 1'b1; b_wbsel[1] = 20; b_done[1] = 1'b1; b_ok[1] = 1'b1;
    tick("R7");
    bit_chk("R7", "bit20 set wins", p0[20], 1'b1);

    // completion without result
    idle(); b_busy = 4'b1100; b_done[2] = 1'b1; b_done[3] = 1'b1;
    tick("R5");
    bit_chk("R5", "bit21 no-result clear", p0[21], 1'b0);
    bit_chk("R5", "bit20 no-result clear", p0[20], 1'b0);

    // latch dropped when not busy
    idle(); issue(0, 1, 1, 9);
    tick("R2");
    idle();
    tick("R6");
    idle(); b_busy[0] = 1'b1; b_done[0] = 1'b1;
    tick("R6");
    bit_chk("R6", "bit9 kept after dropped latch", p0[9], 1'b1);
    idle(); b_busy[0] = 1'b1; b_wb[0] = 1'b1; b_wbsel[0] = 9; b_done[0] = 1'b1; b_ok[0] = 1'b1;
    tick("R3");
    bit_chk("R3", "bit9 cleared", p0[9], 1'b0);

    // done with valid result but no writeback
    idle(); issue(1, 1, 1, 11);
    tick("R2");
    idle(); b_busy[1] = 1'b1; b_done[1] = 1'b1; b_ok[1] = 1'b1;
    tick("R5");
    bit_chk("R5", "bit11 kept on valid result", p0[11], 1'b1);
    idle(); b_wb[1] = 1'b1; b_wbsel[1] = 11;
    tick("R3");
    bit_chk("R3", "bit11 cleared", p0[11], 1'b0);

    // full check vector
    idle(); b_chk = '1;
    tick("R8");
    bit_chk("R8", "no hazard when empty", h0, 1'b0);
    idle(); issue(2, 1, 1, 31);
    tick("R8");
    bit_chk("R8", "hazard on bit31", h0, 1'b1);
    idle(); b_wb[3] = 1'b1; b_wbsel[3] = 31;
    tick("R3");

    // random traffic
    for (int cyc = 0; cyc < 3000; cyc++) begin
      idle();
      b_chk = NREG'($urandom & $urandom & $urandom);
      for (int i = 0; i < NREQ; i++) begin
        if (!rs_act[i]) begin
          if ($urandom % 3 == 0) begin
            issue(i, ($urandom % 8) != 0, ($urandom % 5) != 0, int'($urandom % NREG));
            if (b_sel[i]) begin
              rs_act[i] = 1'b1;
              rs_cnt[i] = 1 + int'($urandom % 4);
              rs_wr[i]  = b_wr[i];
              rs_dst[i] = b_dst[i];
              rs_res[i] = ($urandom % 10) < 7;
            end
          end
        end else begin
          b_busy[i] = 1'b1;
          rs_cnt[i]--;
          if (rs_cnt[i] == 0) begin
            b_done[i] = 1'b1;
            if (rs_wr[i] && rs_res[i]) begin
              b_wb[i] = 1'b1;
              b_wbsel[i] = rs_dst[i];
              b_ok[i] = 1'b1;
            end else begin
              b_ok[i] = rs_wr[i] ? 1'b0 : 1'($urandom % 2);
            end
            rs_act[i] = 1'b0;
          end
        end
      end
      tick("R9");
    end

    fin = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!fin) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule